// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block turns one supplied start address into the address stream for a burst of up to four accesses. A single load/advance control chooses, on every rising clock edge, between taking a fresh base address from the address inputs and stepping to the next beat of the current burst. Only the two least significant address bits move during a burst. The upper bits keep the value captured at load time.

A static order-select input picks how the low two bits are visited. In interleaved order, the start value is XORed with the beat number. In linear order, the beat number is added to the start value modulo four. The access type (access enable and write enable) is captured only at load time and held while the burst advances. A flag marks the cycle that follows a load as a new access, as opposed to a burst continuation. All outputs are registered state, except the low address bits: those are mapped combinationally from the registered base, the beat count and the order select.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `addr_out`=0, `beat`=0, `new_access`=0, `acc_valid`=0 and `acc_write`=0.
- R2: A clock edge with `adv_ld`=0 loads the base address. Afterwards, `addr_out` equals the sampled `addr_in`, `beat` is 0 and `new_access` is 1.
- R3: A clock edge with `adv_ld`=1 increments `beat` by one modulo 4 and clears `new_access`.
- R4: With `order_sel`=1 (interleaved), `addr_out[1:0]` equals the loaded low bits XOR `beat`. For example, start 01 yields 01, 00, 11, 10.
- R5: With `order_sel`=0 (linear), `addr_out[1:0]` equals the loaded low bits plus `beat`, modulo 4. For example, start 10 yields 10, 11, 00, 01.
- R6: `addr_out[ADDR_W-1:2]` does not change while advancing, including when the low bits wrap, so no carry enters bit 2.
- R7: While advancing, `acc_en` and `wr_en` are ignored. `acc_valid` and `acc_write` keep the values sampled at the last load.
- R8: Advancing after the fourth beat returns `beat` to 0, and `addr_out` returns to the loaded start address.
- R9: A load in the middle of a burst restarts the sequence at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_ld | input | 1 | 0 = load new base address, 1 = advance the burst |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start address sampled on load |
| acc_en | input | 1 | Access enable, sampled on load only |
| wr_en | input | 1 | Write enable, sampled on load only |
| addr_out | output | ADDR_W | Current access address |
| beat | output | 2 | Beat number within the burst |
| new_access | output | 1 | 1 in the cycle after a load, 0 during continuation |
| acc_valid | output | 1 | Access enable latched at load |
| acc_write | output | 1 | Write enable latched at load |

## Verification
The bench first runs interleaved bursts from odd start values, where a design that added instead of XORing would produce the wrong second and fourth addresses. It then runs linear bursts whose low bits wrap from 11 to 00. A design that let the carry reach bit 2 would corrupt the upper address there, and an all-ones start address makes that carry as visible as possible. Toggling `acc_en` and `wr_en` during advance beats exposes a design that resamples the access type. A fifth advance and a load in the middle of a burst expose a beat counter that saturates or does not restart. A reset asserted during a burst checks that every output clears.

// File: rtl/bas_pkg.sv
// Package: shared types and the low-bit ordering function for the burst
// address sequencer. Assumes a burst length of four (two low address bits).
package bas_pkg;
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Map a start value and beat number to the visited low address bits.
    function automatic beat_t map_low(order_e ord, beat_t start, beat_t n);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ n;
        else                       r = start + n;
        return r;
    endfunction
endpackage

// File: rtl/bas_beat_ctr.sv
// Module: beat counter for one burst. Clears on reset and on load, and
// steps modulo 2**BEAT_W on advance. Assumes load and step are exclusive.
module bas_beat_ctr
    import bas_pkg::*;
#(
    parameter int CW = BEAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [CW-1:0] count
);
    // Counter update: clear on reset/load, wrap-increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= '0;
        else if (step)  count <= count + 1'b1;
    end
endmodule

// File: rtl/bas_access_reg.sv
// Module: latches the access type on load and holds it through advance
// beats. Also flags the first cycle after a load. Assumes one-cycle load pulses.
module bas_access_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en_in,
    input  logic wr_in,
    output logic valid_q,
    output logic write_q,
    output logic first_q
);
    // Access type capture: sampled only when a new base address loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            write_q <= 1'b0;
        end else if (load) begin
            valid_q <= en_in;
            write_q <= wr_in;
        end
    end

    // New-access flag: high for the cycle that follows a load.
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= load;
    end
endmodule

// File: rtl/bas_order_map.sv
// Module: combinational address former. Keeps the upper bits of the base
// and replaces the low bits with the ordered beat value. Assumes ADDR_W > 2.
module bas_order_map
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  logic              ord_il,
    output logic [ADDR_W-1:0] addr
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    order_e ord;
    beat_t  low;

    // Ordering select and low-bit mapping.
    always_comb begin
        ord = ord_il ? ORD_INTERLEAVE : ORD_LINEAR;
        low = map_low(ord, base[BEAT_W-1:0], beat);
    end

    // Bit assembly: upper bits pass straight through, so no carry reaches them.
    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
            if (gi < BEAT_W) begin : g_low
                assign addr[gi] = low[gi];
            end else begin : g_up
                assign addr[gi] = base[gi];
            end
        end
    endgenerate

    if (UPPER_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed the beat width");
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer. A low adv_ld loads a base
// address and the access type. A high adv_ld steps through up to four beats.
// Assumes order_sel is static during a burst.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_ld,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              acc_en,
    input  logic              wr_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat,
    output logic              new_access,
    output logic              acc_valid,
    output logic              acc_write
);
    logic              do_load;
    logic              do_step;
    logic [ADDR_W-1:0] base_q;
    beat_t             cnt;

    // Control decode: the single pin chooses load or advance.
    always_comb begin
        do_load = !adv_ld;
        do_step = adv_ld;
    end

    // Base address register: captured on load, held while advancing.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (do_load) base_q <= addr_in;
    end

    bas_beat_ctr #(.CW(BEAT_W)) i_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .step  (do_step),
        .count (cnt)
    );

    bas_access_reg i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_load),
        .en_in   (acc_en),
        .wr_in   (wr_en),
        .valid_q (acc_valid),
        .write_q (acc_write),
        .first_q (new_access)
    );

    bas_order_map #(.ADDR_W(ADDR_W)) i_map (
        .base   (base_q),
        .beat   (cnt),
        .ord_il (order_sel),
        .addr   (addr_out)
    );

    assign beat = cnt;
endmodule

// File: rtl/bas_chk.sv
// Module: property checker for burst_addr_seq, attached with bind below.
module bas_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_ld,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic              acc_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat,
    input logic              new_access,
    input logic              acc_valid,
    input logic              acc_write
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0 && beat == 2'd0 && !new_access && !acc_valid && !acc_write));

    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_ld |=> (new_access && beat == 2'd0 && addr_out == $past(addr_in)));

    p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> (beat == $past(beat) + 2'd1 && !new_access));

    p_ileave_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && order_sel) |=>
            (!order_sel || (addr_out[1:0] ^ beat) == $past(addr_out[1:0] ^ beat)));

    p_linear_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && !order_sel) |=>
            (order_sel || (addr_out[1:0] - beat) == $past(addr_out[1:0] - beat)));

    p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    p_type_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> ($stable(acc_valid) && $stable(acc_write)));
endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W)) i_bas_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_ld     (adv_ld),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .acc_en     (acc_en),
    .wr_en      (wr_en),
    .addr_out   (addr_out),
    .beat       (beat),
    .new_access (new_access),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int NVEC = 17;

    typedef struct packed {
        logic          adv;
        logic          ord;
        logic          en;
        logic          wr;
        logic [AW-1:0] a_in;
        logic [AW-1:0] e_addr;
        logic [1:0]    e_beat;
        logic          e_new;
        logic          e_val;
        logic          e_wr;
    } vec_t;

    // adv ord en wr addr_in exp_addr beat new valid write
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b1,1'b1,1'b0,20'h12341,20'h12341,2'd0,1'b1,1'b1,1'b0}, // R2 load, interleaved
        '{1'b1,1'b1,1'b0,1'b1,20'h00000,20'h12340,2'd1,1'b0,1'b1,1'b0}, // R4 R7
        '{1'b1,1'b1,1'b0,1'b1,20'h00000,20'h12343,2'd2,1'b0,1'b1,1'b0}, // R4
        '{1'b1,1'b1,1'b0,1'b1,20'h00000,20'h12342,2'd3,1'b0,1'b1,1'b0}, // R4
        '{1'b1,1'b1,1'b0,1'b1,20'h00000,20'h12341,2'd0,1'b0,1'b1,1'b0}, // R8 wrap
        '{1'b0,1'b0,1'b1,1'b1,20'hABCDE,20'hABCDE,2'd0,1'b1,1'b1,1'b1}, // R2 linear load
        '{1'b1,1'b0,1'b0,1'b0,20'h00000,20'hABCDF,2'd1,1'b0,1'b1,1'b1}, // R5 R7
        '{1'b1,1'b0,1'b0,1'b0,20'h00000,20'hABCDC,2'd2,1'b0,1'b1,1'b1}, // R5 R6 no carry
        '{1'b1,1'b0,1'b0,1'b0,20'h00000,20'hABCDD,2'd3,1'b0,1'b1,1'b1}, // R5
        '{1'b1,1'b0,1'b0,1'b0,20'h00000,20'hABCDE,2'd0,1'b0,1'b1,1'b1}, // R8
        '{1'b0,1'b0,1'b0,1'b0,20'hFFFFF,20'hFFFFF,2'd0,1'b1,1'b0,1'b0}, // R2 all ones
        '{1'b1,1'b0,1'b1,1'b1,20'h00000,20'hFFFFC,2'd1,1'b0,1'b0,1'b0}, // R6 R7
        '{1'b0,1'b1,1'b1,1'b1,20'h00003,20'h00003,2'd0,1'b1,1'b1,1'b1}, // R9 mid-burst load
        '{1'b1,1'b1,1'b0,1'b0,20'h00000,20'h00002,2'd1,1'b0,1'b1,1'b1}, // R4
        '{1'b1,1'b1,1'b0,1'b0,20'h00000,20'h00001,2'd2,1'b0,1'b1,1'b1}, // R4
        '{1'b0,1'b1,1'b1,1'b0,20'h55552,20'h55552,2'd0,1'b1,1'b1,1'b0}, // R9
        '{1'b1,1'b1,1'b0,1'b1,20'h00000,20'h55553,2'd1,1'b0,1'b1,1'b0}  // R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_ld = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          acc_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;
    logic          new_access;
    logic          acc_valid;
    logic          acc_write;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .adv_ld(adv_ld), .order_sel(order_sel),
        .addr_in(addr_in), .acc_en(acc_en), .wr_en(wr_en),
        .addr_out(addr_out), .beat(beat), .new_access(new_access),
        .acc_valid(acc_valid), .acc_write(acc_write)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        // Reset state, R1
        repeat (3) @(negedge clk);
        check("R1", "addr", addr_out, 0);
        check("R1", "beat", beat, 0);
        check("R1", "flags", {new_access, acc_valid, acc_write}, 0);
        rst_n = 1'b1;

        // Table walk: drive on the falling edge, check on the next falling edge
        for (int i = 0; i < NVEC; i++) begin
            adv_ld = VEC[i].adv; order_sel = VEC[i].ord;
            acc_en = VEC[i].en;  wr_en = VEC[i].wr; addr_in = VEC[i].a_in;
            @(negedge clk);
            check(VEC[i].ord ? "R4" : "R5", "addr", addr_out, VEC[i].e_addr);
            check(VEC[i].adv ? "R3" : "R2", "beat", beat, VEC[i].e_beat);
            check(VEC[i].adv ? "R3" : "R2", "new_access", new_access, VEC[i].e_new);
            check("R7", "type", {acc_valid, acc_write}, {VEC[i].e_val, VEC[i].e_wr});
        end

        // Reset in the middle of a burst, R1
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-burst addr", addr_out, 0);
        check("R1", "mid-burst beat", beat, 0);
        check("R1", "mid-burst flags", {new_access, acc_valid, acc_write}, 0);
        rst_n = 1'b1;

        // Linear wrap across the top of the low bits with the upper bits held, R6 R8
        adv_ld = 1'b0; order_sel = 1'b0; addr_in = 20'h7FFFD; acc_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        adv_ld = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R6", "upper bits", addr_out[AW-1:2], 18'h1FFFF);
            check("R5", "low bits", addr_out[1:0], 2'(2'b01 + k));
        end
        check("R8", "wrapped to start", addr_out, 20'h7FFFD);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule